// File: doc/BRIEF.md
# Counter-Compare Gray-Shade Sequencer

This block sets the hold time of each of a row of display column channels against one ramp that all channels share. Each channel has a 7-bit gray code waiting in an input latch. A load-count strobe copies every waiting code into a second latch that belongs to that channel, and it clears all channel outputs. Because of this second latch, the input latches can take the next row while the current row converts.

When the load-count strobe falls, conversion begins. Every channel raises its track enable, so its hold capacitor follows the external ramp. Each rising edge of the count clock then advances one shared step counter. A channel drops its track enable on the step at which the counter passes that channel's code, and from then on it holds the ramp level it had reached. A larger code therefore tracks for longer and ends at a higher level. After 128 steps every channel is holding and a done flag rises. The ramp and the analog hold stage are outside this block.

Both strobes are levels sampled on `clk_i`. Edges are found inside the block, and every response shows on the outputs one clock after the edge is first sampled.

Top module: `gs_sequencer`

## Requirements
- R1: On a load-count rising edge, every channel copies its code from `data_i` into its own comparator latch. The code for channel i sits at bits [7i+6:7i]. Changes to `data_i` after that edge have no effect on the conversion that follows.
- R2: On the clock after a load-count rising edge, `clear_o` is 1, every `track_o` bit is 0, `done_o` is 0 and the step count is back at zero. This holds even if a conversion was already running.
- R3: On the clock after a load-count falling edge, every `track_o` bit is 1 and `clear_o` is 0. Conversion has started at step 0.
- R4: During conversion, each sampled rising edge of `cc_i` adds one to the step count. `track_o[i]` falls on the clock after the edge that moves the count from the channel's code c to c+1, and it never rises again within that conversion.
- R5: A channel with code 0 tracks for exactly one step. A channel with code 127 tracks through all 128 steps.
- R6: `done_o` rises on the clock after the 128th step. From then on all `track_o` bits are 0.
- R7: Count-clock edges after the 128th step are ignored. The outputs and `done_o` keep their values.
- R8: Count-clock edges are ignored while load-count is high and before the first load-count after reset. All `track_o` bits stay 0 and `done_o` stays 0.
- R9: A count-clock edge sampled in the same clock as a load-count falling edge is not counted. A count-clock edge sampled in the same clock as a load-count rising edge loses to the load.
- R10: While `rst_ni` is low and after it is released, `track_o` is 0, `clear_o` is 0 and `done_o` is 0 until the first load-count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 224 | Input latch codes, 7 bits per channel, channel i at [7i+6:7i] |
| lc_i | input | 1 | Load-count strobe level |
| cc_i | input | 1 | Count-clock strobe level |
| track_o | output | 32 | Per-channel ramp-track enable |
| clear_o | output | 1 | Outputs-cleared flag, high during load-count |
| done_o | output | 1 | Conversion finished after 128 steps |

## Verification
The functions that can fall in the same cycle are a count-clock step and a load-count edge. The bench provokes this twice. First it drops load-count in the same cycle that it raises the count clock, with a code-0 channel loaded. That channel must still be tracking afterwards, which shows the edge was not counted. Second, it raises load-count and the count clock together in the middle of a conversion, and the result must be a clean cleared state. A behavioural model, built on a step integer and a phase number, is compared with all three outputs on every clock.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_CONV = 2'd2,
    PH_DONE = 2'd3
  } gs_phase_e;
endpackage

// File: rtl/gs_step_ctrl.sv
module gs_step_ctrl
  import gs_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lc_i,
  input  logic              cc_i,
  output logic              load_o,
  output logic              start_o,
  output logic              adv_o,
  output logic [CODE_W-1:0] step_o,
  output logic              clear_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] STEP_LAST = '1;

  logic              lc_q, cc_q, cc_rise;
  gs_phase_e         phase_q;
  logic [CODE_W-1:0] step_q;

  assign load_o  = lc_i & ~lc_q;
  assign start_o = ~lc_i & lc_q;
  assign cc_rise = cc_i & ~cc_q;
  // load-count edges win over a coincident count step
  assign adv_o   = cc_rise & (phase_q == PH_CONV) & ~load_o & ~start_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_q    <= 1'b0;
      cc_q    <= 1'b0;
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else begin
      lc_q <= lc_i;
      cc_q <= cc_i;
      if (load_o) begin
        phase_q <= PH_LOAD;
        step_q  <= '0;
      end else if (start_o) begin
        phase_q <= PH_CONV;
        step_q  <= '0;
      end else if (adv_o) begin
        // last step ends conversion; counter saturates instead of wrapping
        if (step_q == STEP_LAST) phase_q <= PH_DONE;
        else                     step_q  <= step_q + 1'b1;
      end
    end
  end

  assign step_o  = step_q;
  assign clear_o = (phase_q == PH_LOAD);
  assign done_o  = (phase_q == PH_DONE);
endmodule

// File: rtl/gs_channel.sv
module gs_channel #(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [CODE_W-1:0] step_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              track_o
);
  logic [CODE_W-1:0] code_q;
  logic              flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      flag_q <= 1'b0;
    end else if (load_i) begin
      code_q <= code_i;
      flag_q <= 1'b0;
    end else if (start_i) begin
      flag_q <= 1'b1;
    end else if (adv_i && (step_i == code_q)) begin
      flag_q <= 1'b0;
    end
  end

  assign track_o = flag_q;
endmodule

// File: rtl/gs_sequencer.sv
module gs_sequencer #(
  parameter int N_CH   = 32,
  parameter int CODE_W = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CH*CODE_W-1:0]   data_i,
  input  logic                     lc_i,
  input  logic                     cc_i,
  output logic [N_CH-1:0]          track_o,
  output logic                     clear_o,
  output logic                     done_o
);
  logic              load, start, adv;
  logic [CODE_W-1:0] step;

  gs_step_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lc_i    (lc_i),
    .cc_i    (cc_i),
    .load_o  (load),
    .start_o (start),
    .adv_o   (adv),
    .step_o  (step),
    .clear_o (clear_o),
    .done_o  (done_o)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    gs_channel #(.CODE_W(CODE_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .start_i (start),
      .adv_i   (adv),
      .step_i  (step),
      .code_i  (data_i[ch*CODE_W +: CODE_W]),
      .track_o (track_o[ch])
    );
  end
endmodule

// File: rtl/gs_sequencer_chk.sv
module gs_sequencer_chk #(
  parameter int N_CH   = 32,
  parameter int CODE_W = 7
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CH*CODE_W-1:0] data_i,
  input logic                   lc_i,
  input logic                   cc_i,
  input logic [N_CH-1:0]        track_o,
  input logic                   clear_o,
  input logic                   done_o
);
  logic lc_p, lc_up, lc_dn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lc_p <= 1'b0;
    else         lc_p <= lc_i;
  end
  assign lc_up = lc_i & ~lc_p;
  assign lc_dn = ~lc_i & lc_p;

  AST_LC_RISE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_up |=> (clear_o && track_o == '0 && !done_o)); // R2
  AST_CLEAR_NO_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> (track_o == '0)); // R2
  AST_LC_FALL_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_dn |=> (track_o == '1 && !clear_o)); // R3
  AST_TRACK_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lc_dn |=> ((track_o & ~$past(track_o)) == '0)); // R4
  AST_DONE_ALL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (track_o == '0)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !lc_up) |=> done_o); // R7
  AST_IDLE_WHILE_LC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_i && lc_p) |=> (track_o == '0 && !done_o)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clear_o && done_o)); // R2
endmodule

bind gs_sequencer gs_sequencer_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_i  (data_i),
  .lc_i    (lc_i),
  .cc_i    (cc_i),
  .track_o (track_o),
  .clear_o (clear_o),
  .done_o  (done_o)
);

// File: tb/gs_sequencer_bench.sv
module gs_sequencer_bench;
  localparam int N = 32;
  localparam int W = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           lc, cc;
  logic [N*W-1:0] data;
  logic [N-1:0]   track;
  logic           clear, done;

  int errors = 0, checks = 0, cyc = 0;

  // reference model
  int m_code [N];
  int m_phase = 0;   // 0 idle, 1 load, 2 conversion
  int m_step  = 0;
  bit m_lcp = 0, m_ccp = 0;

  gs_sequencer u_gs_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .lc_i(lc), .cc_i(cc),
    .track_o(track), .clear_o(clear), .done_o(done)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_step = 0; m_lcp = 0; m_ccp = 0;
      for (int i = 0; i < N; i++) m_code[i] = 0;
    end else begin
      if (lc && !m_lcp) begin
        for (int i = 0; i < N; i++) m_code[i] = int'(data[i*W +: W]);
        m_phase = 1; m_step = 0;
      end else if (!lc && m_lcp) begin
        m_phase = 2; m_step = 0;
      end else if (cc && !m_ccp && m_phase == 2 && m_step < 128) begin
        m_step++;
      end
      m_lcp = lc; m_ccp = cc;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [N-1:0] et;
      for (int i = 0; i < N; i++) et[i] = (m_phase == 2) && (m_step <= m_code[i]);
      chk("R4 model track", 64'(track), 64'(et));
      chk("R2 model clear", 64'(clear), 64'(m_phase == 1));
      chk("R6 model done", 64'(done), 64'(m_phase == 2 && m_step == 128));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic cc_pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) cc = 1'b1;
      @(negedge clk) cc = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; lc = 1'b0; cc = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset track", 64'(track), 64'h0);
    chk("R10 reset flags", 64'({clear, done}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", 64'({track, clear, done}), 64'h0);

    cc_pulse(3);
    chk("R8 cc before first load", 64'({track, done}), 64'h0);

    // pattern A: ch0=0, ch31=127, others 4i+1
    for (int i = 0; i < N; i++)
      data[i*W +: W] = (i == 0) ? 7'd0 : (i == N-1) ? 7'd127 : 7'(4*i+1);
    @(negedge clk) lc = 1'b1;
    @(negedge clk);
    chk("R2 clear on load", 64'(clear), 64'h1);
    chk("R2 tracks off on load", 64'(track), 64'h0);
    cc_pulse(2);
    chk("R8 cc while load high", 64'({track, done}), 64'h0);
    data = '0;
    @(negedge clk) lc = 1'b0;
    @(negedge clk);
    chk("R3 all track at start", 64'(track), 64'hFFFF_FFFF);
    chk("R3 clear low at start", 64'(clear), 64'h0);

    cc_pulse(1);
    chk("R5 code0 one step", 64'(track[0]), 64'h0);
    chk("R5 code127 still tracking", 64'(track[N-1]), 64'h1);
    cc_pulse(1);
    chk("R1 latched code survives data change", 64'(track[1]), 64'h1);
    cc_pulse(3);
    chk("R4 code5 at step5", 64'(track[1]), 64'h1);
    cc_pulse(1);
    chk("R4 code5 ends at step6", 64'(track[1]), 64'h0);
    chk("R4 code9 still tracking", 64'(track[2]), 64'h1);
    cc_pulse(121);
    chk("R5 only code127 at step127", 64'(track), 64'h8000_0000);
    chk("R6 not done at step127", 64'(done), 64'h0);
    cc_pulse(1);
    chk("R6 done after 128 steps", 64'(done), 64'h1);
    chk("R6 all held", 64'(track), 64'h0);
    cc_pulse(3);
    chk("R7 extra cc ignored", 64'({track, clear, done}), 64'h1);

    // pattern B: ch31=0, others 127-4i; cc coincident with load fall
    for (int i = 0; i < N; i++)
      data[i*W +: W] = (i == N-1) ? 7'd0 : 7'(127 - 4*i);
    @(negedge clk) lc = 1'b1;
    @(negedge clk);
    @(negedge clk) begin lc = 1'b0; cc = 1'b1; end
    @(negedge clk) cc = 1'b0;
    chk("R9 cc on load fall not counted", 64'(track[N-1]), 64'h1);
    cc_pulse(10);
    chk("R4 pattern B mid", 64'(track[N-1]), 64'h0);
    @(negedge clk) begin lc = 1'b1; cc = 1'b1; end
    @(negedge clk) cc = 1'b0;
    chk("R9 load rise wins over cc", 64'({track, clear, done}), 64'h2);
    chk("R2 abort resets", 64'(track), 64'h0);
    @(negedge clk) lc = 1'b0;
    @(negedge clk);
    chk("R3 restart", 64'(track), 64'hFFFF_FFFF);
    cc_pulse(128);
    chk("R6 second conversion done", 64'({track, done}), 64'h1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule